// File: doc/BRIEF.md
# Set-Associative Cache Tag and Maintenance Controller

This block keeps the bookkeeping half of a small set-associative cache: one valid bit and one tag for every line, plus a replacement pointer for every set. It does not store line data and does not fetch from memory. A lookup port takes an address and answers one cycle later. The answer says whether the address hit, which way hit, and which way the set would replace on a miss. A fill port writes a tag into the way that the set's replacement pointer selects.

Software controls the cache through a four-word register port. It can turn the cache on and off, read back whether the cache is really on, invalidate a single line given its set index and way, and invalidate every line at once. A single line may only be invalidated while the cache is confirmed off. After that, the invalidated way becomes the next fill target of its set.

With default parameters the cache has 4 ways and 32 sets. A 16-bit address splits into a 4-bit line offset in bits [3:0], a 5-bit set index in bits [8:4] and a 7-bit tag in bits [15:9].

Top module: `cache_maint_unit`

## Requirements
- R1: During reset and after it, every line is invalid, the enable and status bits read 0, and every set's replacement pointer is way 0.
- R2: While the status bit is 0, every lookup reports a miss and fills are dropped. A dropped fill writes no tag and does not move the pointer.
- R3: A write to register 0 loads bit 0 of the write data into the enable bit. A read of register 0 returns the enable bit in bit 0.
- R4: A read of register 1 returns the status bit in bit 0. Read data appears on the cycle after the read address is presented. The status bit copies the enable bit one cycle after it changes, but it holds its value in any cycle in which a lookup is presented.
- R5: A lookup presented in one cycle is answered in the next cycle with `lk_resp_valid` high. `lk_hit` is high when the set holds a valid line with a matching tag, and `lk_way` then names that way.
- R6: `lk_victim` gives the set's replacement pointer at the time of the lookup. A fill writes to that way, marks it valid, and advances the pointer by one, wrapping from way 3 to way 0.
- R7: A write to register 2 invalidates exactly one line: the way is taken from write bits [1:0] and the set index from bits [6:2]. No other line changes.
- R8: A line invalidation loads that set's replacement pointer with the invalidated way.
- R9: A write to register 2 while the status bit is 1 is ignored.
- R10: A write to register 3 with bit 0 set clears every valid bit in one cycle. A lookup in that same cycle reports a miss. A fill in that same cycle is dropped and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for reads and writes: 0 enable, 1 status, 2 line invalidate, 3 invalidate all |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the address presented on the previous cycle |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 16 | Lookup address |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | 16 | Fill address (the index and tag are written) |
| lk_resp_valid | output | 1 | Lookup answer valid |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 2 | Way that hit |
| lk_victim | output | 2 | Replacement pointer of the looked-up set |

## Verification
Lookup answers and register read data both arrive one cycle after the request. Control writes change the enable bit at the next edge, and the status bit follows one edge after that. Fills and line invalidations take effect at the edge on which they are presented. The bench drives inputs on falling edges. Each lookup's expected answer is queued when the request is driven, and a monitor compares it on the falling edge where `lk_resp_valid` shows. Register reads are sampled one falling edge after the address is driven. This is why a status read made right after a control write is expected to return the old value, and the next read is expected to return the new one.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_LINE = 2'd2,
    SEL_ALL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cmu_ctrl_regs.sv
module cmu_ctrl_regs
  import cmu_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int WAY_W = 2,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             lk_busy,
  output logic             cen,
  output logic             csts,
  output logic             line_inv,
  output logic [IDX_W-1:0] line_idx,
  output logic [WAY_W-1:0] line_way,
  output logic             inv_all,
  output logic [REG_W-1:0] rdata
);
  reg_sel_e         sel_e;
  logic [REG_W-1:0] rd_word;
  logic             unused_wbits;

  assign sel_e        = reg_sel_e'(sel);
  assign unused_wbits = ^wdata[REG_W-1:WAY_W+IDX_W];

  // maintenance decodes; line invalidate only while status shows disabled
  assign line_way = wdata[WAY_W-1:0];
  assign line_idx = wdata[WAY_W+IDX_W-1:WAY_W];
  assign line_inv = wr_en && (sel_e == SEL_LINE) && !csts;
  assign inv_all  = wr_en && (sel_e == SEL_ALL) && wdata[0];

  always_comb begin
    rd_word = '0;
    case (sel_e)
      SEL_CTRL: rd_word[0] = cen;
      SEL_STAT: rd_word[0] = csts;
      default:  rd_word    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cen   <= 1'b0;
      csts  <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr_en && (sel_e == SEL_CTRL)) cen <= wdata[0];
      // status waits while a lookup is being accepted
      if (!lk_busy) csts <= cen;
      rdata <= rd_word;
    end
  end
endmodule

// File: rtl/cmu_way_bank.sv
module cmu_way_bank #(
  parameter int SETS  = 32,
  parameter int IDX_W = 5,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             match,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  vld;

  // tag store: plain write port, no reset, asynchronous read
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
  end

  // valid bits kept in flops so a global clear is a single cycle
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      vld <= '0;
    end else begin
      if (fill_en) vld[fill_idx] <= 1'b1;
      if (inv_en)  vld[inv_idx]  <= 1'b0;
    end
  end

  assign match = vld[lk_idx] && (tag_mem[lk_idx] == lk_tag);
endmodule

// File: rtl/cmu_repl_table.sv
module cmu_repl_table #(
  parameter int SETS  = 32,
  parameter int WAYS  = 4,
  parameter int IDX_W = 5,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAY_W-1:0] victim,
  input  logic             adv_en,
  input  logic [IDX_W-1:0] adv_idx,
  output logic [WAY_W-1:0] adv_way,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [WAY_W-1:0] load_way
);
  logic [WAY_W-1:0] ptr [SETS];

  assign victim  = ptr[rd_idx];
  assign adv_way = ptr[adv_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptr[s] <= '0;
    end else begin
      if (adv_en)
        ptr[adv_idx] <= (ptr[adv_idx] == WAY_W'(WAYS-1)) ? '0 : ptr[adv_idx] + WAY_W'(1);
      // invalidation reload wins over a fill advance on the same set
      if (load_en) ptr[load_idx] <= load_way;
    end
  end
endmodule

// File: rtl/cache_maint_unit.sv
module cache_maint_unit #(
  parameter int SETS   = 32,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int REG_W  = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              lk_resp_valid,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic [WAY_W-1:0]  lk_victim
);
  logic             cen_w, csts_w, line_inv, inv_all;
  logic [IDX_W-1:0] line_idx;
  logic [WAY_W-1:0] line_way;
  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic [WAYS-1:0]  match_vec;
  logic [WAY_W-1:0] hit_way, victim, fill_way;
  logic             fill_ok;
  logic             unused_off;

  assign lk_idx     = lk_addr[OFF_W +: IDX_W];
  assign lk_tag     = lk_addr[ADDR_W-1 -: TAG_W];
  assign fill_idx   = fill_addr[OFF_W +: IDX_W];
  assign fill_tag   = fill_addr[ADDR_W-1 -: TAG_W];
  assign unused_off = ^{lk_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

  cmu_ctrl_regs #(.IDX_W(IDX_W), .WAY_W(WAY_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(reg_addr), .wdata(reg_wdata),
    .lk_busy(lk_valid), .cen(cen_w), .csts(csts_w), .line_inv(line_inv),
    .line_idx(line_idx), .line_way(line_way), .inv_all(inv_all), .rdata(reg_rdata)
  );

  // fills only land while enabled and not colliding with a global clear
  assign fill_ok = fill_valid && csts_w && !inv_all;

  cmu_repl_table #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_repl (
    .clk(clk), .rst(rst), .rd_idx(lk_idx), .victim(victim),
    .adv_en(fill_ok), .adv_idx(fill_idx), .adv_way(fill_way),
    .load_en(line_inv), .load_idx(line_idx), .load_way(line_way)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cmu_way_bank #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_bank (
      .clk(clk), .rst(rst), .clr_all(inv_all),
      .lk_idx(lk_idx), .lk_tag(lk_tag), .match(match_vec[w]),
      .fill_en(fill_ok && (fill_way == WAY_W'(w))), .fill_idx(fill_idx), .fill_tag(fill_tag),
      .inv_en(line_inv && (line_way == WAY_W'(w))), .inv_idx(line_idx)
    );
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match_vec[w]) hit_way = WAY_W'(w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_resp_valid <= 1'b0;
      lk_hit        <= 1'b0;
      lk_way        <= '0;
      lk_victim     <= '0;
    end else begin
      lk_resp_valid <= lk_valid;
      lk_hit        <= lk_valid && csts_w && !inv_all && (|match_vec);
      lk_way        <= hit_way;
      lk_victim     <= victim;
    end
  end
endmodule

// File: rtl/cmu_checker.sv
module cmu_checker (
  input logic clk,
  input logic rst,
  input logic cen,
  input logic csts,
  input logic inv_all,
  input logic lk_valid,
  input logic lk_resp_valid,
  input logic lk_hit
);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!csts && !lk_hit && !lk_resp_valid));

  assert_off_no_hit_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_resp_valid && !$past(csts)) |-> !lk_hit);

  assert_status_follows_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(lk_valid) |-> (csts == $past(cen)));

  assert_status_holds_R4: assert property (@(posedge clk) disable iff (rst)
    $past(lk_valid) |-> $stable(csts));

  assert_hit_has_resp_R5: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_resp_valid);

  assert_clear_all_miss_R10: assert property (@(posedge clk) disable iff (rst)
    $past(inv_all) |-> !lk_hit);
endmodule

bind cache_maint_unit cmu_checker u_chk (
  .clk(clk), .rst(rst), .cen(cen_w), .csts(csts_w), .inv_all(inv_all),
  .lk_valid(lk_valid), .lk_resp_valid(lk_resp_valid), .lk_hit(lk_hit)
);

// File: tb/cache_maint_unit_tb.sv
module cache_maint_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        lk_valid;
  logic [15:0] lk_addr;
  logic        fill_valid;
  logic [15:0] fill_addr;
  logic        lk_resp_valid, lk_hit;
  logic [1:0]  lk_way, lk_victim;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_hit_q[$];
  int exp_way_q[$];
  int exp_vic_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_maint_unit u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .lk_resp_valid(lk_resp_valid),
    .lk_hit(lk_hit), .lk_way(lk_way), .lk_victim(lk_victim)
  );

  function automatic logic [15:0] mk(input int tag, input int idx);
    return {7'(tag), 5'(idx), 4'h0};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && lk_resp_valid) begin
      if (exp_hit_q.size() == 0) begin
        check("R5 unexpected response", 1, 0);
      end else begin
        automatic bit    eh = exp_hit_q.pop_front();
        automatic int    ew = exp_way_q.pop_front();
        automatic int    ev = exp_vic_q.pop_front();
        automatic string t  = tag_q.pop_front();
        check({t, " hit"}, int'(lk_hit), int'(eh));
        if (eh) check({t, " way"}, int'(lk_way), ew);
        check({t, " victim"}, int'(lk_victim), ev);
      end
    end
  end

  task automatic push_exp(input bit h, input int w, input int v, input string t);
    exp_hit_q.push_back(h); exp_way_q.push_back(w);
    exp_vic_q.push_back(v); tag_q.push_back(t);
  endtask

  // all tasks start and end on a falling edge
  task automatic lookup(input logic [15:0] a, input bit h, input int w, input int v, input string t);
    push_exp(h, w, v, t);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [15:0] a);
    fill_valid = 1'b1; fill_addr = a;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, input int exp, input string t);
    reg_addr = a;
    @(negedge clk);
    check(t, int'(reg_rdata), exp);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    lk_valid = 1'b0; lk_addr = '0; fill_valid = 1'b0; fill_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 resp idle in reset", int'(lk_resp_valid), 0);
    rst = 1'b0;
    reg_read(2'd0, 0, "R1 enable reads 0");
    reg_read(2'd1, 0, "R1 status reads 0");

    // disabled: miss, fill dropped
    lookup(mk(1, 3), 0, 0, 0, "R2 disabled lookup");
    fill(mk(1, 3));

    // enable and status lag
    reg_write(2'd0, 16'h0001);
    reg_read(2'd1, 0, "R4 status lags write");
    reg_read(2'd1, 1, "R4 status now set");
    reg_read(2'd0, 1, "R3 enable reads 1");
    lookup(mk(1, 3), 0, 0, 0, "R2 dropped fill left no line");

    // round-robin fills in set 3
    fill(mk(1, 3)); fill(mk(2, 3)); fill(mk(3, 3)); fill(mk(4, 3));
    lookup(mk(2, 3), 1, 1, 0, "R5 hit way1");
    lookup(mk(4, 3), 1, 3, 0, "R6 wrap hit way3");
    lookup(mk(9, 3), 0, 0, 0, "R6 victim after wrap");
    fill(mk(9, 3));
    lookup(mk(1, 3), 0, 0, 1, "R6 replaced way0");
    lookup(mk(2, 7), 0, 0, 0, "R6 other set untouched");
    fill(mk(5, 7));

    // line invalidate ignored while enabled
    reg_write(2'd2, 16'((3 << 2) | 1));
    lookup(mk(2, 3), 1, 1, 1, "R9 ignored while enabled");

    // disable with a lookup in flight: status holds one cycle
    reg_write(2'd0, 16'h0000);
    lookup(mk(2, 3), 1, 1, 1, "R4 lookup in flight still enabled");
    reg_read(2'd1, 1, "R4 status held by lookup");
    reg_read(2'd1, 0, "R4 status cleared");
    reg_read(2'd0, 0, "R3 enable reads 0");
    lookup(mk(2, 3), 0, 0, 1, "R2 disabled no hit");

    // line invalidate while disabled
    reg_write(2'd2, 16'((3 << 2) | 3));
    reg_write(2'd0, 16'h0001);
    tick();
    lookup(mk(4, 3), 0, 0, 3, "R7 R8 line gone victim3");
    lookup(mk(2, 3), 1, 1, 3, "R7 neighbour way1 kept");
    lookup(mk(9, 3), 1, 0, 3, "R7 neighbour way0 kept");
    fill(mk(6, 3));
    lookup(mk(6, 3), 1, 3, 0, "R8 fill used invalidated way");

    // invalidate all with lookup in the same cycle
    push_exp(0, 0, 0, "R10 same-cycle lookup misses");
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0001;
    lk_valid = 1'b1; lk_addr = mk(6, 3);
    @(negedge clk);
    reg_wr = 1'b0; lk_valid = 1'b0;
    lookup(mk(5, 7), 0, 0, 1, "R10 set7 cleared");
    lookup(mk(2, 3), 0, 0, 0, "R10 set3 cleared");

    // invalidate all with fill in the same cycle
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0001;
    fill_valid = 1'b1; fill_addr = mk(8, 7);
    @(negedge clk);
    reg_wr = 1'b0; fill_valid = 1'b0;
    lookup(mk(8, 7), 0, 0, 1, "R10 fill dropped pointer kept");
    fill(mk(8, 7));
    lookup(mk(8, 7), 1, 1, 2, "R6 fill after clear");

    repeat (3) tick();
    check("R5 all responses seen", exp_hit_q.size(), 0);
    summary();
    $finish;
  end
endmodule